// File: doc/BRIEF.md
# Complex Energy Maximum Selector

This block is one step of a greedy sparse-recovery loop. Complex projection coefficients arrive as a stream, one per candidate atom and in candidate order. For each coefficient the block forms the energy re² + im² at full precision. It tracks the candidate with the greatest energy, skipping every atom that the current support already contains. When a pass closes, it returns three results: the winning index, the support with that atom added, and a flag that says no candidate qualified.

A pass ends on the beat flagged `in_last`, or on the beat at index `N_CAND-1`, whichever comes first. The next pass may begin on the very next cycle. The input is a valid/ready stream whose beat transfers on a cycle where both are high. The block never applies back-pressure: `in_ready` is low only while reset is held and during the first cycle after it. A producer may hold `in_valid` low for any number of cycles inside a pass. Beats with `in_valid` low carry nothing. The result pins are plain status outputs qualified by the one-cycle `res_done` strobe. They keep their values until the next strobe.

Top module: `energy_argmax_sel`

## Requirements
- R1: The energy of a beat is the full-precision sum re² + im² of its two signed `COEF_W`-bit parts, with no truncation. Example: (-131072, 0) has energy 2^34, which is larger than the energy of (131071, 1).
- R2: When a pass contains at least one eligible candidate, `res_idx` is the index of the eligible candidate with the greatest energy. Candidate index i is the i-th accepted beat of the pass, counting from 0.
- R3: When eligible candidates tie on the greatest energy, the one with the lowest index wins.
- R4: A candidate whose bit i in `supp_in` is 1 when its beat is accepted is never selected, whatever its energy.
- R5: When a selection is made, `res_mask` equals `supp_in` with bit `res_idx` also set. `supp_in` is sampled on the final beat and must be held steady for the whole pass.
- R6: The pass reports no selection when every candidate is masked or has zero energy. In that case `res_none` is 1, `res_idx` is 0 and `res_mask` equals `supp_in` unchanged.
- R7: `res_done` is high for exactly one cycle per pass. It is visible in the cycle after the second rising edge that follows the acceptance of the final beat, and it is never high at any other time.
- R8: A pass with no `in_last` closes on its `N_CAND`-th beat, and the following beat starts a new pass at index 0.
- R9: One cycle after reset is released, `in_ready` is high and stays high. Cycles with `in_valid` low do not affect the result, whatever the data pins carry.
- R10: While reset is held, `in_ready`, `res_done`, `res_none`, `res_idx` and `res_mask` are all 0.
- R11: A new pass may start on the cycle right after the final beat of the previous pass. Both passes then report their own correct results on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Coefficient beat is present |
| in_ready | output | 1 | Block accepts a beat this cycle |
| in_re | input | COEF_W | Real part, two's complement |
| in_im | input | COEF_W | Imaginary part, two's complement |
| in_last | input | 1 | This beat closes the pass |
| supp_in | input | N_CAND | Current support; bit i marks candidate i as taken |
| res_done | output | 1 | One-cycle strobe, results valid |
| res_idx | output | IDX_W | Selected candidate index |
| res_none | output | 1 | No eligible candidate in the pass |
| res_mask | output | N_CAND | Support with the selected bit added |

## Verification
The assertions rely on one assumption about the inputs: `supp_in` does not change from the cycle after a pass's first beat until the pass closes. Under that assumption, the mask sampled on the final beat is the mask that governed the whole pass, and the checker compares `res_mask` against that sample. The stimulus sets the mask before the first beat of each pass and changes it only between passes. In every pass the flag `in_last` is placed at or before index `N_CAND-1`, except in the one pass that deliberately runs to the count limit.

// File: rtl/emax_pkg.sv
package emax_pkg;
  localparam int unsigned DEF_N_CAND = 101;
  localparam int unsigned DEF_COEF_W = 18;

  function automatic int unsigned idx_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/emax_stage.sv
// Input stage: squares and sums the coefficient, looks up its support bit
// and registers everything the comparator needs one cycle later.
module emax_stage #(
  parameter int unsigned N_CAND = 101,
  parameter int unsigned COEF_W = 18,
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned EN_W   = 37
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     take_beat,
  input  logic signed [COEF_W-1:0] re,
  input  logic signed [COEF_W-1:0] im,
  input  logic [IDX_W-1:0]         idx,
  input  logic                     is_first,
  input  logic                     is_end,
  input  logic [N_CAND-1:0]        mask,
  output logic                     s_valid,
  output logic [EN_W-1:0]          s_energy,
  output logic [IDX_W-1:0]         s_idx,
  output logic                     s_skip,
  output logic                     s_first,
  output logic                     s_end,
  output logic [N_CAND-1:0]        s_mask
);
  logic signed [2*COEF_W-1:0] re_sq;
  logic signed [2*COEF_W-1:0] im_sq;
  logic [EN_W-1:0]            energy;

  always_comb begin
    re_sq  = re * re;
    im_sq  = im * im;
    energy = EN_W'($unsigned(re_sq)) + EN_W'($unsigned(im_sq));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_valid  <= 1'b0;
      s_energy <= '0;
      s_idx    <= '0;
      s_skip   <= 1'b0;
      s_first  <= 1'b0;
      s_end    <= 1'b0;
      s_mask   <= '0;
    end else begin
      s_valid <= take_beat;
      if (take_beat) begin
        s_energy <= energy;
        s_idx    <= idx;
        s_skip   <= mask[idx];
        s_first  <= is_first;
        s_end    <= is_end;
        s_mask   <= mask;
      end
    end
  end
endmodule

// File: rtl/emax_track.sv
// Running maximum over eligible candidates; publishes the result on the
// closing beat of a pass.
module emax_track #(
  parameter int unsigned N_CAND = 101,
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned EN_W   = 37
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic [EN_W-1:0]   s_energy,
  input  logic [IDX_W-1:0]  s_idx,
  input  logic              s_skip,
  input  logic              s_first,
  input  logic              s_end,
  input  logic [N_CAND-1:0] s_mask,
  output logic              res_done,
  output logic [IDX_W-1:0]  res_idx,
  output logic              res_none,
  output logic [N_CAND-1:0] res_mask
);
  logic [EN_W-1:0]   best_e;
  logic [IDX_W-1:0]  best_idx;
  logic              best_ok;
  logic              eligible;
  logic              take;
  logic              nxt_ok;
  logic [EN_W-1:0]   nxt_e;
  logic [IDX_W-1:0]  nxt_idx;
  logic [N_CAND-1:0] pick_bits;

  always_comb begin
    eligible = !s_skip && (s_energy != '0);
    // strict greater-than keeps the earlier index on a tie
    take     = eligible && (s_first || !best_ok || (s_energy > best_e));
    nxt_ok   = take || (!s_first && best_ok);
    nxt_e    = take ? s_energy : best_e;
    nxt_idx  = take ? s_idx : best_idx;
  end

  for (genvar g = 0; g < N_CAND; g++) begin : g_pick
    assign pick_bits[g] = nxt_ok && (nxt_idx == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      best_e   <= '0;
      best_idx <= '0;
      best_ok  <= 1'b0;
      res_done <= 1'b0;
      res_idx  <= '0;
      res_none <= 1'b0;
      res_mask <= '0;
    end else begin
      res_done <= s_valid && s_end;
      if (s_valid) begin
        best_e   <= nxt_e;
        best_idx <= nxt_idx;
        best_ok  <= nxt_ok;
        if (s_end) begin
          res_idx  <= nxt_ok ? nxt_idx : '0;
          res_none <= !nxt_ok;
          res_mask <= s_mask | pick_bits;
        end
      end
    end
  end
endmodule

// File: rtl/energy_argmax_sel.sv
module energy_argmax_sel
  import emax_pkg::*;
#(
  parameter  int unsigned N_CAND = DEF_N_CAND,
  parameter  int unsigned COEF_W = DEF_COEF_W,
  localparam int unsigned IDX_W  = idx_bits(N_CAND),
  localparam int unsigned EN_W   = 2 * COEF_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [COEF_W-1:0] in_re,
  input  logic signed [COEF_W-1:0] in_im,
  input  logic                     in_last,
  input  logic [N_CAND-1:0]        supp_in,
  output logic                     res_done,
  output logic [IDX_W-1:0]         res_idx,
  output logic                     res_none,
  output logic [N_CAND-1:0]        res_mask
);
  logic             ready_q;
  logic [IDX_W-1:0] cnt;
  logic             accept;
  logic             beat_end;

  logic              s_valid;
  logic [EN_W-1:0]   s_energy;
  logic [IDX_W-1:0]  s_idx;
  logic              s_skip;
  logic              s_first;
  logic              s_end;
  logic [N_CAND-1:0] s_mask;

  assign in_ready = ready_q;
  assign accept   = in_valid && ready_q;
  assign beat_end = in_last || (cnt == IDX_W'(N_CAND - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      cnt     <= '0;
    end else begin
      ready_q <= 1'b1;
      if (accept) cnt <= beat_end ? '0 : cnt + 1'b1;
    end
  end

  emax_stage #(
    .N_CAND(N_CAND), .COEF_W(COEF_W), .IDX_W(IDX_W), .EN_W(EN_W)
  ) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_beat(accept),
    .re       (in_re),
    .im       (in_im),
    .idx      (cnt),
    .is_first (cnt == '0),
    .is_end   (beat_end),
    .mask     (supp_in),
    .s_valid  (s_valid),
    .s_energy (s_energy),
    .s_idx    (s_idx),
    .s_skip   (s_skip),
    .s_first  (s_first),
    .s_end    (s_end),
    .s_mask   (s_mask)
  );

  emax_track #(
    .N_CAND(N_CAND), .IDX_W(IDX_W), .EN_W(EN_W)
  ) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (s_valid),
    .s_energy(s_energy),
    .s_idx   (s_idx),
    .s_skip  (s_skip),
    .s_first (s_first),
    .s_end   (s_end),
    .s_mask  (s_mask),
    .res_done(res_done),
    .res_idx (res_idx),
    .res_none(res_none),
    .res_mask(res_mask)
  );
endmodule

// File: rtl/emax_chk.sv
module emax_chk #(
  parameter int unsigned N_CAND = 101,
  parameter int unsigned IDX_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_last,
  input logic [N_CAND-1:0] supp_in,
  input logic              res_done,
  input logic [IDX_W-1:0]  res_idx,
  input logic              res_none,
  input logic [N_CAND-1:0] res_mask
);
  int unsigned       beats;
  logic              end_q;
  logic [N_CAND-1:0] snap_q;
  logic [N_CAND-1:0] snap2;
  logic              closing;

  assign closing = in_valid && in_ready && (in_last || beats == N_CAND - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beats  <= 0;
      end_q  <= 1'b0;
      snap_q <= '0;
      snap2  <= '0;
    end else begin
      end_q <= closing;
      snap2 <= snap_q;
      if (closing) snap_q <= supp_in;
      if (in_valid && in_ready) beats <= closing ? 0 : beats + 1;
    end
  end

  AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (beats != 0) |-> $stable(supp_in)); // R5
  AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    end_q |=> res_done); // R7
  AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !end_q |=> !res_done); // R7
  AST_KEEP_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> ((res_mask & snap2) == snap2)); // R5
  AST_ONE_NEW_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> ($countones(res_mask & ~snap2) == (res_none ? 0 : 1))); // R5
  AST_FRESH_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && !res_none) |-> (!snap2[res_idx] && res_mask[res_idx])); // R4
  AST_NONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && res_none) |-> (res_idx == '0 && res_mask == snap2)); // R6
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> (int'(res_idx) < N_CAND)); // R2
  AST_READY_UP: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> in_ready); // R9
endmodule

bind energy_argmax_sel emax_chk #(.N_CAND(N_CAND), .IDX_W(IDX_W)) u_emax_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .in_last (in_last),
  .supp_in (supp_in),
  .res_done(res_done),
  .res_idx (res_idx),
  .res_none(res_none),
  .res_mask(res_mask)
);

// File: tb/test_energy_argmax_sel.sv
module test_energy_argmax_sel;
  localparam int N  = 101;
  localparam int CW = 18;
  localparam int IW = 7;
  localparam int NT = 8;

  // rows: T5 exercises R1 (full width) with R3; T1 ties R3; T2 masking R4; T3/T4 R6
  localparam int TV_LEN  [NT] = '{4, 3, 4, 3, 5, 3, 8, 1};
  localparam int TV_MASK [NT] = '{0, 0, 1, 7, 0, 0, 'hA5, 0};
  localparam int TV_IDX  [NT] = '{2, 0, 2, 0, 0, 1, 6, 0};
  localparam int TV_NONE [NT] = '{0, 0, 0, 1, 1, 0, 0, 0};
  localparam int TV_RE [NT][8] = '{
    '{3, 0, -6, 1, 0, 0, 0, 0},
    '{5, 0, 3, 0, 0, 0, 0, 0},
    '{100, 10, -20, 0, 0, 0, 0, 0},
    '{4, 5, 6, 0, 0, 0, 0, 0},
    '{0, 0, 0, 0, 0, 0, 0, 0},
    '{131071, -131072, 0, 0, 0, 0, 0, 0},
    '{9, 1, 50, -7, 0, 30, -9, 40},
    '{0, 0, 0, 0, 0, 0, 0, 0}};
  localparam int TV_IM [NT][8] = '{
    '{4, 5, 0, 1, 0, 0, 0, 0},
    '{0, -5, 4, 0, 0, 0, 0, 0},
    '{0, 10, 1, 0, 0, 0, 0, 0},
    '{1, 1, 1, 0, 0, 0, 0, 0},
    '{0, 0, 0, 0, 0, 0, 0, 0},
    '{1, 0, -131072, 0, 0, 0, 0, 0},
    '{9, 2, 0, -7, 8, 30, -5, 0},
    '{1, 0, 0, 0, 0, 0, 0, 0}};

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic signed [CW-1:0] in_re = '0;
  logic signed [CW-1:0] in_im = '0;
  logic                 in_last = 1'b0;
  logic [N-1:0]         supp_in = '0;
  logic                 res_done;
  logic [IW-1:0]        res_idx;
  logic                 res_none;
  logic [N-1:0]         res_mask;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  energy_argmax_sel #(.N_CAND(N), .COEF_W(CW)) i_energy_argmax_sel (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .in_last(in_last), .supp_in(supp_in),
    .res_done(res_done), .res_idx(res_idx), .res_none(res_none), .res_mask(res_mask)
  );

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic beat(input int re, input int im, input bit last);
    in_valid = 1'b1;
    in_re    = CW'(re);
    in_im    = CW'(im);
    in_last  = last;
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = 1'b0;
    in_last  = 1'b0;
    in_re    = CW'(-131072);
    in_im    = CW'(-131072);
  endtask

  // called at the negedge right after the final beat was accepted
  task automatic expect_result(input string req, input int idx, input bit none,
                               input logic [127:0] mask_in);
    logic [127:0] em;
    em = mask_in;
    if (!none) em[idx] = 1'b1;
    idle();
    chk("R7", "done not yet", 128'(res_done), 128'(0));
    @(negedge clk);
    chk("R7", "done strobe", 128'(res_done), 128'(1));
    chk(req, "index", 128'(res_idx), 128'(none ? 0 : idx));
    chk(none ? "R6" : req, "none flag", 128'(res_none), 128'(none));
    chk(none ? "R6" : "R5", "mask", 128'(res_mask), em);
    @(negedge clk);
    chk("R7", "done single cycle", 128'(res_done), 128'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog expired actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    chk("R10", "ready in reset", 128'(in_ready), 128'(0));
    chk("R10", "done in reset", 128'(res_done), 128'(0));
    chk("R10", "idx in reset", 128'(res_idx), 128'(0));
    chk("R10", "none in reset", 128'(res_none), 128'(0));
    chk("R10", "mask in reset", 128'(res_mask), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "ready after reset", 128'(in_ready), 128'(1));

    // table of passes, one loop
    for (int t = 0; t < NT; t++) begin
      supp_in = N'(TV_MASK[t]);
      for (int b = 0; b < TV_LEN[t]; b++)
        beat(TV_RE[t][b], TV_IM[t][b], b == TV_LEN[t] - 1);
      expect_result("R2", TV_IDX[t], TV_NONE[t] != 0, 128'(TV_MASK[t]));
    end

    // R9: gaps with garbage data while valid is low
    supp_in = '0;
    beat(3, 4, 1'b0);  idle(); @(negedge clk); @(negedge clk);
    beat(0, 5, 1'b0);  idle(); @(negedge clk);
    beat(-6, 0, 1'b0); idle(); @(negedge clk);
    beat(1, 1, 1'b1);
    expect_result("R9", 2, 1'b0, 128'(0));

    // R11: back-to-back passes
    supp_in = '0;
    beat(1, 0, 1'b0);
    beat(5, 5, 1'b1);
    beat(7, 0, 1'b1);
    idle();
    chk("R11", "first pass done", 128'(res_done), 128'(1));
    chk("R11", "first pass idx", 128'(res_idx), 128'(1));
    chk("R11", "first pass mask", 128'(res_mask), 128'(2));
    @(negedge clk);
    chk("R11", "second pass done", 128'(res_done), 128'(1));
    chk("R11", "second pass idx", 128'(res_idx), 128'(0));
    chk("R11", "second pass mask", 128'(res_mask), 128'(1));
    @(negedge clk);
    chk("R11", "done drops", 128'(res_done), 128'(0));

    // R8: full-length pass without last, largest value masked at 99
    begin
      logic [127:0] m;
      m = '0;
      m[99] = 1'b1;
      supp_in = N'(m);
      for (int b = 0; b < N; b++)
        beat((b == 99) ? 50 : (b == 100) ? 2 : 1, 0, 1'b0);
      expect_result("R8", 100, 1'b0, m);
    end
    supp_in = '0;
    beat(0, 1, 1'b0);
    beat(0, 3, 1'b1);
    expect_result("R8", 1, 1'b0, 128'(0));

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule